// File: doc/BRIEF.md
# Ordered Combination Lock

This block is a small clocked state machine that releases a lock only after three dial operations arrive in one fixed order. Each operation is a turn direction (right or left) together with a dial number. A strobe marks the cycle in which the pair is valid. The machine records how far the user has progressed through the sequence. When the last step matches, it drives its open output high.

The number of correct values entered does not decide the result: both the direction and the position of each value in the sequence must match. A wrong operation discards all progress. When that operation is itself the first step, it counts as a new start instead. Once the lock is open it stays open and ignores further operations until a relock pulse closes it. The three steps are parameters. Their defaults are right 13, then left 22, then right 3.

Top module: `combo_lock_fsm`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets `progress` to 2'b00 and drives `unlocked` low from that edge on, whatever the machine held before.
- R2: `progress` shows the machine state in two bits: 2'b00 idle, 2'b01 first step matched, 2'b10 two steps matched, 2'b11 open. `unlocked` is high exactly when `progress` is 2'b11.
- R3: Right 13, then left 22, then right 3, each presented with `op_valid`, moves `progress` 00→01→10→11. `unlocked` rises on the edge that samples the third operation. The same values in any other order do not open the lock.
- R4: An edge with `op_valid` low leaves `progress` unchanged, whatever `op_dir` and `op_val` carry.
- R5: From a closed state, a valid operation that is not the expected next step sets `progress` to 2'b00. If that operation equals the first step (right 13), `progress` becomes 2'b01 instead.
- R6: Direction is part of each step (`op_dir` 0 = right, 1 = left). A correct value with the wrong direction counts as a wrong operation.
- R7: While `progress` is 2'b11, valid operations have no effect and the lock stays open.
- R8: `relock` high on an edge sets `progress` to 2'b00 from any state. It takes priority over a valid operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Marks an operation in this cycle |
| op_dir | input | 1 | Turn direction, 0 right, 1 left |
| op_val | input | VAL_W | Dial number of the operation |
| relock | input | 1 | Closes the lock and clears progress |
| unlocked | output | 1 | High while the lock is open |
| progress | output | 2 | Current state code |

## Verification
A relock pulse and a valid operation can land on the same edge. The bench provokes this twice. In one case the operation would complete the sequence from the two-step state. In the other it is the sequence's first step from the open state. Both cases are judged by reading `progress` and `unlocked` one cycle later, where only the idle code with the output low is accepted.

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm #(
  parameter int unsigned VAL_W = 6,
  parameter bit          S0_DIR = 1'b0,
  parameter int unsigned S0_VAL = 13,
  parameter bit          S1_DIR = 1'b1,
  parameter int unsigned S1_VAL = 22,
  parameter bit          S2_DIR = 1'b0,
  parameter int unsigned S2_VAL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_dir,
  input  logic [VAL_W-1:0] op_val,
  input  logic             relock,
  output logic             unlocked,
  output logic [1:0]       progress
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_OPEN = 2'b11
  } lock_st_e;

  localparam logic [VAL_W:0] STEP0 = {S0_DIR, VAL_W'(S0_VAL)};
  localparam logic [VAL_W:0] STEP1 = {S1_DIR, VAL_W'(S1_VAL)};
  localparam logic [VAL_W:0] STEP2 = {S2_DIR, VAL_W'(S2_VAL)};

  lock_st_e st_q, st_d;
  logic [VAL_W:0] op;
  logic hit0, hit1, hit2;

  assign op   = {op_dir, op_val};
  assign hit0 = (op == STEP0);
  assign hit1 = (op == STEP1);
  assign hit2 = (op == STEP2);

  always_comb begin
    st_d = st_q;
    if (relock) begin
      st_d = ST_IDLE;
    end else if (op_valid) begin
      unique case (st_q)
        ST_IDLE: st_d = hit0 ? ST_ONE : ST_IDLE;
        ST_ONE:  st_d = hit1 ? ST_TWO  : (hit0 ? ST_ONE : ST_IDLE);
        ST_TWO:  st_d = hit2 ? ST_OPEN : (hit0 ? ST_ONE : ST_IDLE);
        ST_OPEN: st_d = ST_OPEN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign progress = st_q;
  assign unlocked = (st_q == ST_OPEN);

endmodule

// File: rtl/combo_lock_fsm_chk.sv
module combo_lock_fsm_chk #(
  parameter int unsigned VAL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             op_dir,
  input logic [VAL_W-1:0] op_val,
  input logic             relock,
  input logic             unlocked,
  input logic [1:0]       progress
);

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (progress == 2'b00 && !unlocked));

  a_r2_open_code: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (progress == 2'b11));

  a_r3_opens_after_two: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(progress) == 2'b10 && $past(op_valid)));

  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> $stable(progress));

  a_r7_open_sticks: assert property (@(posedge clk) disable iff (rst)
    (progress == 2'b11 && !relock) |=> (progress == 2'b11));

  a_r8_relock_wins: assert property (@(posedge clk) disable iff (rst)
    relock |=> (progress == 2'b00 && !unlocked));

  a_r5_step_limit: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !relock && progress != 2'b11) |=>
      (progress == 2'b00 || progress == 2'b01 || progress == $past(progress) + 2'b01));

endmodule

bind combo_lock_fsm combo_lock_fsm_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
  .op_val(op_val), .relock(relock), .unlocked(unlocked), .progress(progress)
);

// File: tb/combo_lock_fsm_bench.sv
module combo_lock_fsm_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_dir = 1'b0;
  logic [5:0] op_val = '0;
  logic relock = 1'b0;
  logic unlocked;
  logic [1:0] progress;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  combo_lock_fsm u_combo_lock_fsm (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
    .op_val(op_val), .relock(relock), .unlocked(unlocked), .progress(progress)
  );

  // {relock, valid, dir, val, expected progress}
  localparam int NV = 24;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 1'b0, 6'd13, 2'd0},  // R4 strobe low
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},  // R3
    {1'b0, 1'b1, 1'b1, 6'd22, 2'd2},  // R3
    {1'b0, 1'b1, 1'b0, 6'd3,  2'd3},  // R3 opens
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd3},  // R7
    {1'b0, 1'b1, 1'b1, 6'd9,  2'd3},  // R7
    {1'b1, 1'b0, 1'b0, 6'd0,  2'd0},  // R8
    {1'b0, 1'b1, 1'b1, 6'd13, 2'd0},  // R6 wrong direction on first step
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},  // R5 restart on first step
    {1'b0, 1'b1, 1'b1, 6'd22, 2'd2},
    {1'b0, 1'b1, 1'b1, 6'd5,  2'd0},  // R5 wrong value
    {1'b0, 1'b1, 1'b1, 6'd22, 2'd0},  // R3 out of order
    {1'b0, 1'b1, 1'b0, 6'd3,  2'd0},  // R3 out of order
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},
    {1'b0, 1'b1, 1'b0, 6'd22, 2'd0},  // R6 right 22
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},
    {1'b0, 1'b1, 1'b1, 6'd22, 2'd2},
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},  // R5 first step from two-step state
    {1'b0, 1'b1, 1'b1, 6'd22, 2'd2},
    {1'b1, 1'b1, 1'b0, 6'd3,  2'd0},  // R8 relock beats completing op
    {1'b0, 1'b1, 1'b0, 6'd13, 2'd1},
    {1'b0, 1'b1, 1'b1, 6'd22, 2'd2},
    {1'b0, 1'b0, 1'b0, 6'd3,  2'd2}   // R4 right data, no strobe
  };

  task automatic check(input string tag, input logic [1:0] exp);
    checks++;
    if (progress !== exp || unlocked !== (exp == 2'd3)) begin
      fails++;
      $display("FAIL %s: progress=%0d unlocked=%0b expected progress=%0d unlocked=%0b",
               tag, progress, unlocked, exp, (exp == 2'd3));
    end
  endtask

  task automatic drive(input logic rl, input logic v, input logic d, input logic [5:0] val);
    @(negedge clk);
    relock = rl; op_valid = v; op_dir = d; op_val = val;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 2'd0);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:2]);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i), VEC[i][1:0]);
      relock = 1'b0; op_valid = 1'b0;
    end
    // finish sequence, then relock alongside a first-step op while open
    drive(1'b0, 1'b1, 1'b0, 6'd3);
    @(negedge clk);
    check("R3 open", 2'd3);
    relock = 1'b1; op_valid = 1'b1; op_dir = 1'b0; op_val = 6'd13;
    @(negedge clk);
    check("R8 relock with first step", 2'd0);
    relock = 1'b0; op_valid = 1'b0;
    // R1 reset from the open state
    drive(1'b0, 1'b1, 1'b0, 6'd13);
    drive(1'b0, 1'b1, 1'b1, 6'd22);
    drive(1'b0, 1'b1, 1'b0, 6'd3);
    @(negedge clk);
    op_valid = 1'b0;
    check("R3 reopen", 2'd3);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset while open", 2'd0);
    rst = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule